// File: doc/BRIEF.md
# Dual-Address I2C Register Bank Decoder

This block is an I2C target that holds the configuration registers of four signal channels, split into two banks of two channels each. It answers on two adjacent 7-bit addresses: the even one opens bank 0 (channels 2 and 3) and the odd one opens bank 1 (channels 0 and 1). Two strapped multi-level inputs select the address pair. A host writes an offset byte after the address byte and then streams data bytes. To read, it issues a repeated START and clocks bytes out. The offset advances by one after every data byte and wraps from 0xFF to 0x00.

Within a bank the 8-bit offset picks a register window. The first 64 offsets reach the bank's upper channel. The next 64 reach its lower channel. A broadcast window writes one value into the same register of both channels at once; reading that window returns the upper channel's copy. A small shared area per bank holds device-level settings, and a read-only identity byte sits at the top of the offset space. The block samples SCL and SDA with the system clock, so that clock must run well above the bus rate (400 kHz or less).

Top module: `dual_bank_i2c_regs`

## Requirements
- R1: With `mode_lvl` = 1 and `addr_lvl` = a (0..3), the target acknowledges address 0x18+2a (bank 0) and 0x18+2a+1 (bank 1).
- R2: With `mode_lvl` = 2 and `addr_lvl` = a (0..3), the target acknowledges address 0x20+2a (bank 0) and 0x20+2a+1 (bank 1).
- R3: The target acknowledges no address when `addr_lvl` is 4 or more, or when `mode_lvl` is neither 1 nor 2. It never acknowledges an address outside its current pair.
- R4: A write is address(R/W=0), offset byte, then data bytes. A read is a write of the offset followed by a repeated START and address(R/W=1). The target acknowledges the offset and every data byte it receives. The offset increments after every data byte and wraps 0xFF to 0x00. Bits are sent MSB first, and the target changes SDA only while SCL is low.
- R5: Offsets 0x00-0x3F access register (offset & 0x3F) of the bank's upper channel (3 or 1). Offsets 0x40-0x7F access register (offset & 0x3F) of the lower channel (2 or 0). Each channel's storage is independent of every other channel's.
- R6: A write at offset 0x80-0xBF stores the byte into register (offset & 0x3F) of both channels of the addressed bank.
- R7: A read at offset 0x80-0xBF returns register (offset & 0x3F) of the addressed bank's upper channel.
- R8: Offsets 0xE0-0xEF are sixteen read/write shared registers, separate for each bank.
- R9: Offset 0xFF reads 0x5A in both banks, and writes to it are ignored.
- R10: Offsets 0xC0-0xDF and 0xF0-0xFE read 0x00 and ignore writes, yet their data bytes are still acknowledged.
- R11: After reset every channel and shared register reads 0x00 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| mode_lvl | input | 3 | Strapped mode level, 0..4 |
| addr_lvl | input | 3 | Strapped address level, 0..4 |
| scl_i | input | 1 | I2C clock line as seen on the pin |
| sda_i | input | 1 | I2C data line as seen on the pin |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |

## Verification
The checks take for granted that the strap levels are steady throughout a transaction and change only while the bus is idle. They also assume the host moves SDA only while SCL is low, except at START and STOP, and that each SCL phase lasts several system clocks so the synchronised edges are seen in order. The bench keeps every SCL quarter at four clocks, changes the straps only between STOP and the next START, and releases SDA whenever the target may drive it.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

    localparam int OFF_W       = 8;
    localparam int DATA_W      = 8;
    localparam int CH_IDX_W    = 6;
    localparam int CH_DEPTH    = 1 << CH_IDX_W;
    localparam int SH_IDX_W    = 4;
    localparam int SH_DEPTH    = 1 << SH_IDX_W;
    localparam int NUM_BANKS   = 2;
    localparam int CH_PER_BANK = 2;
    localparam int NUM_CH      = NUM_BANKS * CH_PER_BANK;
    localparam int LVL_W       = 3;

    localparam logic [OFF_W-1:0]  LO_WIN_END = 8'h7F;
    localparam logic [OFF_W-1:0]  BC_WIN_END = 8'hBF;
    localparam logic [OFF_W-1:0]  SH_WIN_LO  = 8'hE0;
    localparam logic [OFF_W-1:0]  SH_WIN_HI  = 8'hEF;
    localparam logic [OFF_W-1:0]  ID_OFFSET  = 8'hFF;
    localparam logic [DATA_W-1:0] ID_CONST   = 8'h5A;

    localparam logic [6:0]       BASE_MODE1   = 7'h18;
    localparam logic [6:0]       BASE_MODE2   = 7'h20;
    localparam logic [LVL_W-1:0] ADDR_LVL_RSV = 3'd4;

    typedef enum logic [2:0] {
        WIN_UP, WIN_LO, WIN_BC, WIN_SH, WIN_ID, WIN_NONE
    } win_e;

    typedef struct packed {
        win_e                win;
        logic [CH_IDX_W-1:0] idx;
    } dec_t;

    typedef struct packed {
        logic       valid;
        logic [6:0] base;
    } strap_t;

    typedef struct packed {
        logic              en;
        logic              bank;
        logic [OFF_W-1:0]  off;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    typedef enum logic [3:0] {
        T_IDLE, T_ADDR, T_ADDR_ACK, T_OFFS, T_OFFS_ACK,
        T_WR, T_WR_ACK, T_RD, T_RD_ACK
    } tgt_st_e;

    function automatic dec_t decode_off(input logic [OFF_W-1:0] off);
        dec_t d;
        d.idx = off[CH_IDX_W-1:0];
        if (off <= LO_WIN_END)
            d.win = off[CH_IDX_W] ? WIN_LO : WIN_UP;
        else if (off <= BC_WIN_END)
            d.win = WIN_BC;
        else if (off >= SH_WIN_LO && off <= SH_WIN_HI)
            d.win = WIN_SH;
        else if (off == ID_OFFSET)
            d.win = WIN_ID;
        else
            d.win = WIN_NONE;
        return d;
    endfunction

    function automatic strap_t strap_pair(input logic [LVL_W-1:0] mode,
                                          input logic [LVL_W-1:0] addr);
        strap_t s;
        s.valid = 1'b0;
        s.base  = 7'h00;
        if (addr < ADDR_LVL_RSV) begin
            case (mode)
                3'd1: begin
                    s.valid = 1'b1;
                    s.base  = BASE_MODE1 + {4'b0000, addr[1:0], 1'b0};
                end
                3'd2: begin
                    s.valid = 1'b1;
                    s.base  = BASE_MODE2 + {4'b0000, addr[1:0], 1'b0};
                end
                default: ;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/i2cb_sync.sv
module i2cb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    generate
        if (STAGES <= 1) begin : g_one
            logic q;
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b1;
                else     q <= din;
            end
            assign dout = q;
        end else begin : g_many
            logic [STAGES-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) q <= '1;
                else     q <= {q[STAGES-2:0], din};
            end
            assign dout = q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/i2cb_strap.sv
module i2cb_strap
    import i2cb_pkg::*;
(
    input  logic [LVL_W-1:0] mode_lvl,
    input  logic [LVL_W-1:0] addr_lvl,
    output logic             addr_ok,
    output logic [6:0]       base_addr
);
    strap_t pair;
    always_comb begin
        pair      = strap_pair(mode_lvl, addr_lvl);
        addr_ok   = pair.valid;
        base_addr = pair.base;
    end
endmodule

// File: rtl/i2cb_target.sv
module i2cb_target
    import i2cb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl,
    input  logic              sda,
    input  logic              addr_ok,
    input  logic [6:0]        base_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_bank,
    output logic [OFF_W-1:0]  rd_off,
    output wr_req_t           wr,
    output logic              sda_oe
);
    logic scl_d, sda_d;
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl;
            sda_d <= sda;
        end
    end

    logic scl_rise, scl_fall, start_ev, stop_ev;
    assign scl_rise = scl & ~scl_d;
    assign scl_fall = ~scl & scl_d;
    assign start_ev = scl & scl_d & sda_d & ~sda;
    assign stop_ev  = scl & scl_d & ~sda_d & sda;

    tgt_st_e           st;
    logic [3:0]        cnt;
    logic [DATA_W-1:0] rx, tx;
    logic [OFF_W-1:0]  ptr;
    logic              bank_q, rw_q, mack_q, oe_q;

    logic rx_state, byte_done, hit;
    assign rx_state  = (st == T_ADDR) || (st == T_OFFS) || (st == T_WR);
    assign byte_done = scl_fall && (cnt == 4'd8);
    assign hit       = addr_ok && (rx[7:2] == base_addr[6:1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= T_IDLE;
            cnt    <= '0;
            rx     <= '0;
            tx     <= '0;
            ptr    <= '0;
            bank_q <= 1'b0;
            rw_q   <= 1'b0;
            mack_q <= 1'b0;
            oe_q   <= 1'b0;
            wr     <= '0;
        end else begin
            wr.en <= 1'b0;
            if (start_ev) begin
                st   <= T_ADDR;
                cnt  <= '0;
                oe_q <= 1'b0;
            end else if (stop_ev) begin
                st   <= T_IDLE;
                oe_q <= 1'b0;
            end else begin
                if (rx_state && scl_rise) begin
                    rx  <= {rx[DATA_W-2:0], sda};
                    cnt <= cnt + 4'd1;
                end
                case (st)
                    T_ADDR: if (byte_done) begin
                        if (hit) begin
                            bank_q <= rx[1];
                            rw_q   <= rx[0];
                            oe_q   <= 1'b1;
                            st     <= T_ADDR_ACK;
                        end else begin
                            st <= T_IDLE;
                        end
                    end
                    T_ADDR_ACK: if (scl_fall) begin
                        cnt <= '0;
                        if (rw_q) begin
                            tx   <= rd_data;
                            oe_q <= ~rd_data[DATA_W-1];
                            st   <= T_RD;
                        end else begin
                            oe_q <= 1'b0;
                            st   <= T_OFFS;
                        end
                    end
                    T_OFFS: if (byte_done) begin
                        ptr  <= rx;
                        oe_q <= 1'b1;
                        st   <= T_OFFS_ACK;
                    end
                    T_WR: if (byte_done) begin
                        wr.en   <= 1'b1;
                        wr.bank <= bank_q;
                        wr.off  <= ptr;
                        wr.data <= rx;
                        ptr     <= ptr + 8'd1;
                        oe_q    <= 1'b1;
                        st      <= T_WR_ACK;
                    end
                    T_OFFS_ACK, T_WR_ACK: if (scl_fall) begin
                        oe_q <= 1'b0;
                        cnt  <= '0;
                        st   <= T_WR;
                    end
                    T_RD: begin
                        if (scl_rise) begin
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (cnt == 4'd8) begin
                                oe_q <= 1'b0;
                                ptr  <= ptr + 8'd1;
                                st   <= T_RD_ACK;
                            end else begin
                                oe_q <= ~tx[DATA_W-2];
                                tx   <= {tx[DATA_W-2:0], 1'b0};
                            end
                        end
                    end
                    T_RD_ACK: begin
                        if (scl_rise) begin
                            mack_q <= ~sda;
                        end else if (scl_fall) begin
                            if (mack_q) begin
                                tx   <= rd_data;
                                oe_q <= ~rd_data[DATA_W-1];
                                cnt  <= '0;
                                st   <= T_RD;
                            end else begin
                                st <= T_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_bank = bank_q;
    assign rd_off  = ptr;
    assign sda_oe  = oe_q;
endmodule

// File: rtl/i2cb_regfile.sv
module i2cb_regfile
    import i2cb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr,
    input  logic              rd_bank,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data
);
    dec_t wdec, rdec;
    assign wdec = decode_off(wr.off);
    assign rdec = decode_off(rd_off);

    logic [DATA_W-1:0] ch_rd [NUM_CH];
    logic [DATA_W-1:0] sh_rd [NUM_BANKS];

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            localparam logic [1:0] CID = 2'(c);
            logic [DATA_W-1:0] mem [CH_DEPTH];
            logic              sel;
            always_comb begin
                sel = wr.en && (CID[1] == ~wr.bank) &&
                      ((wdec.win == WIN_UP && CID[0]) ||
                       (wdec.win == WIN_LO && !CID[0]) ||
                       (wdec.win == WIN_BC));
            end
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < CH_DEPTH; i++) mem[i] <= '0;
                end else if (sel) begin
                    mem[wdec.idx] <= wr.data;
                end
            end
            assign ch_rd[c] = mem[rdec.idx];
        end

        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sh
            localparam logic BID = 1'(b);
            logic [DATA_W-1:0] mem [SH_DEPTH];
            logic              sel;
            assign sel = wr.en && (wr.bank == BID) && (wdec.win == WIN_SH);
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < SH_DEPTH; i++) mem[i] <= '0;
                end else if (sel) begin
                    mem[wdec.idx[SH_IDX_W-1:0]] <= wr.data;
                end
            end
            assign sh_rd[b] = mem[rdec.idx[SH_IDX_W-1:0]];
        end
    endgenerate

    always_comb begin
        case (rdec.win)
            WIN_UP, WIN_BC: rd_data = ch_rd[{~rd_bank, 1'b1}];
            WIN_LO:         rd_data = ch_rd[{~rd_bank, 1'b0}];
            WIN_SH:         rd_data = sh_rd[rd_bank];
            WIN_ID:         rd_data = ID_CONST;
            default:        rd_data = '0;
        endcase
    end
endmodule

// File: rtl/dual_bank_i2c_regs.sv
module dual_bank_i2c_regs
    import i2cb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] mode_lvl,
    input  logic [LVL_W-1:0] addr_lvl,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe
);
    logic              scl_s, sda_s;
    logic              addr_valid;
    logic [6:0]        base_addr;
    wr_req_t           wr_req;
    logic              rd_bank;
    logic [OFF_W-1:0]  rd_off;
    logic [DATA_W-1:0] rd_data;

    i2cb_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst(rst), .din(scl_i), .dout(scl_s)
    );
    i2cb_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst(rst), .din(sda_i), .dout(sda_s)
    );

    i2cb_strap u_strap (
        .mode_lvl(mode_lvl), .addr_lvl(addr_lvl),
        .addr_ok(addr_valid), .base_addr(base_addr)
    );

    i2cb_target u_target (
        .clk(clk), .rst(rst), .scl(scl_s), .sda(sda_s),
        .addr_ok(addr_valid), .base_addr(base_addr), .rd_data(rd_data),
        .rd_bank(rd_bank), .rd_off(rd_off), .wr(wr_req), .sda_oe(sda_oe)
    );

    i2cb_regfile u_regs (
        .clk(clk), .rst(rst), .wr(wr_req),
        .rd_bank(rd_bank), .rd_off(rd_off), .rd_data(rd_data)
    );
endmodule

// File: rtl/i2cb_chk.sv
module i2cb_chk
    import i2cb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sda_oe,
    input logic              scl_s,
    input logic              addr_valid,
    input wr_req_t           wr_req,
    input logic [OFF_W-1:0]  rd_off,
    input logic [DATA_W-1:0] rd_data
);
    AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (rst)
        !addr_valid |-> !sda_oe); // R3

    AST_NO_WRITE_UNSTRAPPED: assert property (@(posedge clk) disable iff (rst)
        wr_req.en |-> addr_valid); // R3

    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_s); // R4

    AST_ID_FIXED: assert property (@(posedge clk) disable iff (rst)
        (rd_off == ID_OFFSET) |-> (rd_data == ID_CONST)); // R9

    AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((rd_off >= 8'hC0 && rd_off <= 8'hDF) ||
         (rd_off >= 8'hF0 && rd_off <= 8'hFE)) |-> (rd_data == 8'h00)); // R10

    AST_RESET_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !sda_oe); // R11
endmodule

bind dual_bank_i2c_regs i2cb_chk chk_i (
    .clk(clk), .rst(rst), .sda_oe(sda_oe), .scl_s(scl_s),
    .addr_valid(addr_valid), .wr_req(wr_req),
    .rd_off(rd_off), .rd_data(rd_data)
);

// File: tb/dual_bank_i2c_regs_tb_top.sv
module dual_bank_i2c_regs_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 4;
    localparam int WD_CYCLES  = 195000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] mode_lvl = 3'd1;
    logic [2:0] addr_lvl = 3'd0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic       sda_line;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_bank_i2c_regs dut_i (
        .clk(clk), .rst(rst), .mode_lvl(mode_lvl), .addr_lvl(addr_lvl),
        .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [7:0] mch [4][64];
    logic [7:0] msh [2][16];

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic b, input logic [7:0] o);
        if (o < 8'h40)                   return mch[{~b, 1'b1}][o[5:0]];
        else if (o < 8'h80)              return mch[{~b, 1'b0}][o[5:0]];
        else if (o < 8'hC0)              return mch[{~b, 1'b1}][o[5:0]];
        else if (o >= 8'hE0 && o < 8'hF0) return msh[b][o[3:0]];
        else if (o == 8'hFF)             return 8'h5A;
        else                             return 8'h00;
    endfunction

    task automatic mdl_wr(input logic b, input logic [7:0] o, input logic [7:0] v);
        if (o < 8'h40)                    mch[{~b, 1'b1}][o[5:0]] = v;
        else if (o < 8'h80)               mch[{~b, 1'b0}][o[5:0]] = v;
        else if (o < 8'hC0) begin
            mch[{~b, 1'b1}][o[5:0]] = v;
            mch[{~b, 1'b0}][o[5:0]] = v;
        end else if (o >= 8'hE0 && o < 8'hF0) msh[b][o[3:0]] = v;
    endtask

    function automatic string req_tag(input logic [7:0] o);
        if (o < 8'h80)                    return "R5";
        else if (o < 8'hC0)               return "R7";
        else if (o >= 8'hE0 && o < 8'hF0) return "R8";
        else if (o == 8'hFF)              return "R9";
        else                              return "R10";
    endfunction

    task automatic do_start();
        sda_m = 1'b1; wt(Q);
        scl_m = 1'b1; wt(Q);
        sda_m = 1'b0; wt(Q);
        scl_m = 1'b0; wt(Q);
    endtask

    task automatic do_stop();
        sda_m = 1'b0; wt(Q);
        scl_m = 1'b1; wt(Q);
        sda_m = 1'b1; wt(Q);
    endtask

    task automatic put_bit(input logic v);
        sda_m = v;    wt(Q);
        scl_m = 1'b1; wt(2*Q);
        scl_m = 1'b0; wt(Q);
    endtask

    task automatic get_bit(output logic v);
        sda_m = 1'b1; wt(Q);
        scl_m = 1'b1; wt(Q);
        v = sda_line; wt(Q);
        scl_m = 1'b0; wt(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic line;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(line);
        ack = ~line;
    endtask

    task automatic get_byte(input logic ack_it, output logic [7:0] b);
        logic line;
        for (int i = 7; i >= 0; i--) begin
            get_bit(line);
            b[i] = line;
        end
        put_bit(~ack_it);
    endtask

    function automatic logic [6:0] dev(input logic b);
        return 7'h18 | {6'd0, b};
    endfunction

    task automatic i2c_write(input logic b, input logic [7:0] off, input int n,
                             input logic [7:0] v0, input logic [7:0] stp);
        logic ack;
        logic [7:0] o, v;
        do_start();
        send_byte({dev(b), 1'b0}, ack); check8("R1", {7'd0, ack}, 8'd1);
        send_byte(off, ack);            check8("R4", {7'd0, ack}, 8'd1);
        for (int k = 0; k < n; k++) begin
            o = off + 8'(k);
            v = v0 + 8'(k) * stp;
            send_byte(v, ack);
            check8((req_tag(o) == "R10") ? "R10" : "R4", {7'd0, ack}, 8'd1);
            mdl_wr(b, o, v);
        end
        do_stop();
    endtask

    task automatic i2c_read(input logic b, input logic [7:0] off, input int n, input string tag);
        logic ack;
        logic [7:0] o, d;
        do_start();
        send_byte({dev(b), 1'b0}, ack); check8("R1", {7'd0, ack}, 8'd1);
        send_byte(off, ack);            check8("R4", {7'd0, ack}, 8'd1);
        do_start();
        send_byte({dev(b), 1'b1}, ack); check8("R4", {7'd0, ack}, 8'd1);
        for (int k = 0; k < n; k++) begin
            o = off + 8'(k);
            get_byte(k != n - 1, d);
            check8((tag == "") ? req_tag(o) : tag, d, exp_rd(b, o));
        end
        do_stop();
    endtask

    initial begin
        logic ack;
        logic exp_ack;
        logic [6:0] base;
        for (int c = 0; c < 4; c++)
            for (int i = 0; i < 64; i++) mch[c][i] = 8'h00;
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 16; i++) msh[b][i] = 8'h00;

        wt(5);
        rst = 1'b0;
        wt(3);
        check8("R11", {7'd0, sda_oe}, 8'd0);

        // R1 R2 R3: sweep every strap combination against addresses 0x17..0x28
        for (int m = 0; m < 5; m++) begin
            for (int a = 0; a < 5; a++) begin
                mode_lvl = 3'(m);
                addr_lvl = 3'(a);
                base = (m == 1) ? 7'h18 : 7'h20;
                base = base + 7'(2 * a);
                for (int t = 8'h17; t <= 8'h28; t++) begin
                    exp_ack = (m == 1 || m == 2) && (a < 4) && (7'(t) >> 1 == base >> 1);
                    do_start();
                    send_byte({7'(t), 1'b0}, ack);
                    do_stop();
                    check8(exp_ack ? ((m == 1) ? "R1" : "R2") : "R3",
                           {7'd0, ack}, {7'd0, exp_ack});
                end
            end
        end

        mode_lvl = 3'd1;
        addr_lvl = 3'd0;
        wt(2 * Q);

        // R11: reset contents
        i2c_read(1'b0, 8'h00, 8, "R11");
        i2c_read(1'b1, 8'hE0, 8, "R11");

        // R5: windows and crossing from upper into lower channel
        i2c_write(1'b0, 8'h38, 16, 8'h11, 8'h07);
        i2c_write(1'b1, 8'h78, 16, 8'hC3, 8'h0D);
        // R6: broadcast then read both channels
        i2c_write(1'b0, 8'h90, 8, 8'h60, 8'h05);
        i2c_read(1'b0, 8'h10, 8, "R6");
        i2c_read(1'b0, 8'h50, 8, "R6");
        // R7: make lower differ, broadcast read returns upper copy
        i2c_write(1'b0, 8'h50, 4, 8'hF0, 8'h01);
        i2c_read(1'b0, 8'h90, 4, "R7");
        // R10 R8: holes then shared
        i2c_write(1'b0, 8'hDC, 8, 8'hA1, 8'h11);
        // R9 R4: ID ignores writes, offset wraps into upper channel
        i2c_write(1'b1, 8'hFC, 8, 8'h33, 8'h09);
        i2c_write(1'b1, 8'hE8, 4, 8'h7E, 8'h03);

        i2c_read(1'b0, 8'h00, 256, "");
        i2c_read(1'b1, 8'h00, 16, "");
        i2c_read(1'b1, 8'h40, 16, "");
        i2c_read(1'b1, 8'h78, 32, "");
        i2c_read(1'b1, 8'hC0, 48, "");
        i2c_read(1'b1, 8'hF8, 16, "R4");

        check8("R4", {7'd0, sda_oe}, 8'd0);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule